// File: doc/BRIEF.md
# Memory Field Extension Controller

This block widens a 12-bit minicomputer address to 15 bits by keeping a 3-bit instruction field and a 3-bit data field beside the processor. It decodes the field-management I/O words that the processor passes in on a 12-bit instruction input with a valid strobe. For read-type words it returns a value for the accumulator, together with a load enable in the same cycle.

A request to change the instruction field does not take effect at once. The new field is held in a buffer and moves into the active instruction field only when the processor signals that a jump or subroutine call has committed. While such a change waits, an interrupt-inhibit output is held high. This keeps an interrupt from landing between the field change and the jump.

On interrupt entry the controller copies both fields into a 6-bit save field and clears both fields to zero. Software can later read the save field back, or restore from it. The block also forms the 15-bit address: an instruction fetch takes the instruction field, and an indirect operand access takes the data field.

Top module: `mfx_field_ctrl`

## Requirements
- R1: After reset the instruction field, data field, buffered field and save field are zero, irq_inhibit is low and ac_rd_load is low.
- R2: A valid word whose bits 11:6 are octal 62 and bits 2:0 are 001 (octal 62n1) loads bits 5:3 into the data field on the next clock edge.
- R3: A valid word with bits 11:6 = octal 62 and bits 2:0 = 010 (octal 62n2) loads bits 5:3 into the buffered field and raises irq_inhibit on the next edge. The instruction field does not change.
- R4: A commit_jump pulse while a change is pending copies the buffered field into the instruction field and clears irq_inhibit. A commit_jump pulse with nothing pending has no effect.
- R5: Word octal 6214 drives ac_rd_load high in the same cycle, with ac_rd_data holding the data field in bits 5:3 and zeros elsewhere.
- R6: Word octal 6224 drives ac_rd_load high in the same cycle, with ac_rd_data holding the instruction field in bits 5:3 and zeros elsewhere.
- R7: Word octal 6234 drives ac_rd_load high in the same cycle, with ac_rd_data bits 5:0 holding the save field as {instruction field, data field}.
- R8: Word octal 6244 copies save field bits 5:3 into the buffered field and bits 2:0 into the data field. It also marks a change pending, so the instruction field follows at the next commit_jump.
- R9: An irq_enter pulse saves {instruction field, data field} into the save field and clears both fields on the next edge. In that cycle it overrides any instruction or commit_jump.
- R10: full_addr is {instruction field, addr_in} when addr_sel is 0 and {data field, addr_in} when addr_sel is 1, with no cycle of delay.
- R11: Words whose bits 11:6 are not octal 62, words in the 62 group with any other function code, and any word presented with instr_valid low produce no ac_rd_load and leave all fields unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Qualifies instr for one cycle |
| instr | input | 12 | I/O transfer word from the processor |
| commit_jump | input | 1 | Pulse when a jump or subroutine call commits |
| irq_enter | input | 1 | Pulse on interrupt entry |
| addr_sel | input | 1 | 0 selects instruction field, 1 selects data field |
| addr_in | input | 12 | 12-bit address within a field |
| ac_rd_data | output | 12 | Value for the accumulator |
| ac_rd_load | output | 1 | Accumulator load enable |
| ifield | output | 3 | Active instruction field |
| dfield | output | 3 | Active data field |
| irq_inhibit | output | 1 | High while an instruction-field change is pending |
| full_addr | output | 15 | Field-extended address |

## Verification
The bound checker watches several rules on every cycle. It confirms that the data field follows each 62n1 word and that a 62n2 word raises the inhibit without touching the instruction field. It also confirms that the instruction field moves only on a commit or an interrupt, that interrupt entry zeroes both fields, and that a load enable never appears outside the 62 group. Some results can only be seen through the bench's scenarios, because the save and buffer registers are not visible at the ports. These are the values read back by 6234, the deferred field that 6244 restores, and the precedence of an interrupt over a coincident 62n2 word.

// File: rtl/mfx_pkg.sv
package mfx_pkg;
   typedef enum logic [2:0] {
      MFX_NOP,
      MFX_SET_DATA,
      MFX_SET_INSTR,
      MFX_GET_DATA,
      MFX_GET_INSTR,
      MFX_GET_SAVE,
      MFX_RESTORE
   } mfx_op_e;

   localparam logic [5:0] MFX_GROUP = 6'o62;
   localparam logic [2:0] FN_SET_DATA  = 3'b001;
   localparam logic [2:0] FN_SET_INSTR = 3'b010;
   localparam logic [2:0] FN_READ      = 3'b100;
   localparam logic [2:0] SUB_DATA     = 3'd1;
   localparam logic [2:0] SUB_INSTR    = 3'd2;
   localparam logic [2:0] SUB_SAVE     = 3'd3;
   localparam logic [2:0] SUB_RESTORE  = 3'd4;
endpackage

// File: rtl/mfx_decode.sv
module mfx_decode
   import mfx_pkg::*;
#(
   parameter int WORD_W  = 12,
   parameter int FIELD_W = 3
) (
   input  logic              valid,
   input  logic [WORD_W-1:0] word,
   output mfx_op_e           op,
   output logic [FIELD_W-1:0] fld
);
   if (WORD_W != 12) begin : g_bad_word
      initial $fatal(1, "mfx_decode: WORD_W must be 12");
   end
   if (FIELD_W != 3) begin : g_bad_field
      initial $fatal(1, "mfx_decode: FIELD_W must be 3");
   end

   logic in_group;
   assign in_group = valid && (word[11:6] == MFX_GROUP);
   assign fld      = word[5:3];

   always_comb begin
      op = MFX_NOP;
      if (in_group) begin
         unique case (word[2:0])
            FN_SET_DATA:  op = MFX_SET_DATA;
            FN_SET_INSTR: op = MFX_SET_INSTR;
            FN_READ: begin
               unique case (word[5:3])
                  SUB_DATA:    op = MFX_GET_DATA;
                  SUB_INSTR:   op = MFX_GET_INSTR;
                  SUB_SAVE:    op = MFX_GET_SAVE;
                  SUB_RESTORE: op = MFX_RESTORE;
                  default:     op = MFX_NOP;
               endcase
            end
            default: op = MFX_NOP;
         endcase
      end
   end
endmodule

// File: rtl/mfx_field_regs.sv
module mfx_field_regs
   import mfx_pkg::*;
#(
   parameter int FIELD_W = 3,
   localparam int SAVE_W = 2 * FIELD_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  mfx_op_e            op,
   input  logic [FIELD_W-1:0] fld,
   input  logic               commit,
   input  logic               irq,
   output logic [FIELD_W-1:0] ifield_q,
   output logic [FIELD_W-1:0] dfield_q,
   output logic [FIELD_W-1:0] ibuf_q,
   output logic [SAVE_W-1:0]  save_q,
   output logic               pending_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ifield_q  <= '0;
         dfield_q  <= '0;
         ibuf_q    <= '0;
         save_q    <= '0;
         pending_q <= 1'b0;
      end else if (irq) begin
         save_q   <= {ifield_q, dfield_q};
         ifield_q <= '0;
         dfield_q <= '0;
      end else begin
         if (commit && pending_q) begin
            ifield_q  <= ibuf_q;
            pending_q <= 1'b0;
         end
         unique case (op)
            MFX_SET_DATA: dfield_q <= fld;
            MFX_SET_INSTR: begin
               ibuf_q    <= fld;
               pending_q <= 1'b1;
            end
            MFX_RESTORE: begin
               ibuf_q    <= save_q[SAVE_W-1:FIELD_W];
               dfield_q  <= save_q[FIELD_W-1:0];
               pending_q <= 1'b1;
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/mfx_readback.sv
module mfx_readback
   import mfx_pkg::*;
#(
   parameter int WORD_W  = 12,
   parameter int FIELD_W = 3,
   localparam int SAVE_W = 2 * FIELD_W
) (
   input  mfx_op_e            op,
   input  logic [FIELD_W-1:0] ifield,
   input  logic [FIELD_W-1:0] dfield,
   input  logic [SAVE_W-1:0]  save,
   output logic [WORD_W-1:0]  data,
   output logic               load
);
   always_comb begin
      data = '0;
      load = 1'b0;
      unique case (op)
         MFX_GET_DATA: begin
            data[FIELD_W +: FIELD_W] = dfield;
            load = 1'b1;
         end
         MFX_GET_INSTR: begin
            data[FIELD_W +: FIELD_W] = ifield;
            load = 1'b1;
         end
         MFX_GET_SAVE: begin
            data[SAVE_W-1:0] = save;
            load = 1'b1;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/mfx_addr_form.sv
module mfx_addr_form #(
   parameter int WORD_W   = 12,
   parameter int FIELD_W  = 3,
   parameter bit REG_ADDR = 1'b0,
   localparam int ADDR_W  = WORD_W + FIELD_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sel,
   input  logic [FIELD_W-1:0] ifield,
   input  logic [FIELD_W-1:0] dfield,
   input  logic [WORD_W-1:0]  addr_in,
   output logic [ADDR_W-1:0]  addr_out
);
   logic [ADDR_W-1:0] addr_c;
   assign addr_c = {sel ? dfield : ifield, addr_in};

   if (REG_ADDR) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) addr_out <= '0;
         else        addr_out <= addr_c;
      end
   end else begin : g_comb
      assign addr_out = addr_c;
   end
endmodule

// File: rtl/mfx_field_ctrl.sv
module mfx_field_ctrl
   import mfx_pkg::*;
#(
   parameter int WORD_W   = 12,
   parameter int FIELD_W  = 3,
   parameter bit REG_ADDR = 1'b0,
   localparam int ADDR_W  = WORD_W + FIELD_W,
   localparam int SAVE_W  = 2 * FIELD_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               instr_valid,
   input  logic [WORD_W-1:0]  instr,
   input  logic               commit_jump,
   input  logic               irq_enter,
   input  logic               addr_sel,
   input  logic [WORD_W-1:0]  addr_in,
   output logic [WORD_W-1:0]  ac_rd_data,
   output logic               ac_rd_load,
   output logic [FIELD_W-1:0] ifield,
   output logic [FIELD_W-1:0] dfield,
   output logic               irq_inhibit,
   output logic [ADDR_W-1:0]  full_addr
);
   mfx_op_e            op;
   logic [FIELD_W-1:0] fld;
   logic [FIELD_W-1:0] ibuf;
   logic [SAVE_W-1:0]  save;
   logic               pending;

   mfx_decode #(.WORD_W(WORD_W), .FIELD_W(FIELD_W)) u_dec (
      .valid (instr_valid),
      .word  (instr),
      .op    (op),
      .fld   (fld)
   );

   mfx_field_regs #(.FIELD_W(FIELD_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .op        (op),
      .fld       (fld),
      .commit    (commit_jump),
      .irq       (irq_enter),
      .ifield_q  (ifield),
      .dfield_q  (dfield),
      .ibuf_q    (ibuf),
      .save_q    (save),
      .pending_q (pending)
   );

   mfx_readback #(.WORD_W(WORD_W), .FIELD_W(FIELD_W)) u_rd (
      .op     (op),
      .ifield (ifield),
      .dfield (dfield),
      .save   (save),
      .data   (ac_rd_data),
      .load   (ac_rd_load)
   );

   mfx_addr_form #(.WORD_W(WORD_W), .FIELD_W(FIELD_W), .REG_ADDR(REG_ADDR)) u_addr (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel      (addr_sel),
      .ifield   (ifield),
      .dfield   (dfield),
      .addr_in  (addr_in),
      .addr_out (full_addr)
   );

   assign irq_inhibit = pending;
endmodule

// File: rtl/mfx_field_ctrl_chk.sv
module mfx_field_ctrl_chk #(
   parameter int WORD_W  = 12,
   parameter int FIELD_W = 3
) (
   input logic               clk,
   input logic               rst_n,
   input logic               instr_valid,
   input logic [WORD_W-1:0]  instr,
   input logic               commit_jump,
   input logic               irq_enter,
   input logic [WORD_W-1:0]  ac_rd_data,
   input logic               ac_rd_load,
   input logic [FIELD_W-1:0] ifield,
   input logic [FIELD_W-1:0] dfield,
   input logic               irq_inhibit
);
   logic grp, w_cdf, w_cif, w_rmf, w_rdf;
   assign grp   = instr_valid && (instr[11:6] == 6'o62);
   assign w_cdf = grp && (instr[2:0] == 3'b001);
   assign w_cif = grp && (instr[2:0] == 3'b010);
   assign w_rmf = grp && (instr[2:0] == 3'b100) && (instr[5:3] == 3'd4);
   assign w_rdf = grp && (instr[2:0] == 3'b100) && (instr[5:3] == 3'd1);

   // R2
   cdf_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (w_cdf && !irq_enter) |=> (dfield == $past(instr[5:3])));

   // R3
   cif_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (w_cif && !irq_enter && !commit_jump) |=> (irq_inhibit && ifield == $past(ifield)));

   // R4
   commit_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (commit_jump && irq_inhibit && !irq_enter && !w_cif && !w_rmf) |=> !irq_inhibit);

   // R4
   ifield_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ifield != $past(ifield)) |-> $past(commit_jump || irq_enter));

   // R9
   irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_enter |=> (ifield == '0 && dfield == '0));

   // R11
   load_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ac_rd_load |-> grp);

   // R5
   rdf_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      w_rdf |-> (ac_rd_load && ac_rd_data == (WORD_W'(dfield) << FIELD_W)));
endmodule

bind mfx_field_ctrl mfx_field_ctrl_chk #(.WORD_W(WORD_W), .FIELD_W(FIELD_W)) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .instr_valid (instr_valid),
   .instr       (instr),
   .commit_jump (commit_jump),
   .irq_enter   (irq_enter),
   .ac_rd_data  (ac_rd_data),
   .ac_rd_load  (ac_rd_load),
   .ifield      (ifield),
   .dfield      (dfield),
   .irq_inhibit (irq_inhibit)
);

// File: tb/mfx_field_ctrl_tb.sv
module mfx_field_ctrl_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        instr_valid = 1'b0;
   logic [11:0] instr = '0;
   logic        commit_jump = 1'b0;
   logic        irq_enter = 1'b0;
   logic        addr_sel = 1'b0;
   logic [11:0] addr_in = '0;
   logic [11:0] ac_rd_data;
   logic        ac_rd_load;
   logic [2:0]  ifield, dfield;
   logic        irq_inhibit;
   logic [14:0] full_addr;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   mfx_field_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
      .commit_jump(commit_jump), .irq_enter(irq_enter), .addr_sel(addr_sel),
      .addr_in(addr_in), .ac_rd_data(ac_rd_data), .ac_rd_load(ac_rd_load),
      .ifield(ifield), .dfield(dfield), .irq_inhibit(irq_inhibit),
      .full_addr(full_addr)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0o expected=%0o", req, act, exp);
      end
   endtask

   task automatic issue(input logic [11:0] w);
      @(negedge clk);
      instr = w; instr_valid = 1'b1;
      @(negedge clk);
      instr_valid = 1'b0; instr = '0;
   endtask

   task automatic pulse_commit();
      @(negedge clk); commit_jump = 1'b1;
      @(negedge clk); commit_jump = 1'b0;
   endtask

   task automatic pulse_irq();
      @(negedge clk); irq_enter = 1'b1;
      @(negedge clk); irq_enter = 1'b0;
   endtask

   task automatic read_ac(input logic [11:0] w, input logic [11:0] exp, input string req);
      @(negedge clk);
      instr = w; instr_valid = 1'b1;
      #1;
      chk(ac_rd_load === 1'b1, req, ac_rd_load, 1);
      chk(ac_rd_data === exp, req, ac_rd_data, exp);
      @(negedge clk);
      instr_valid = 1'b0; instr = '0;
   endtask

   task automatic t_reset();
      // R1
      chk(ifield === 3'd0 && dfield === 3'd0, "R1", {ifield, dfield}, 0);
      chk(irq_inhibit === 1'b0, "R1", irq_inhibit, 0);
      chk(ac_rd_load === 1'b0, "R1", ac_rd_load, 0);
      read_ac(12'o6234, 12'o0000, "R1");
   endtask

   task automatic t_data_field();
      issue(12'o6251);
      // R2
      chk(dfield === 3'd5, "R2", dfield, 5);
      read_ac(12'o6214, 12'o0050, "R5");
      // R10
      addr_sel = 1'b1; addr_in = 12'o7777; #1;
      chk(full_addr === 15'o57777, "R10", full_addr, 15'o57777);
      addr_sel = 1'b0; #1;
      chk(full_addr === 15'o07777, "R10", full_addr, 15'o07777);
   endtask

   task automatic t_instr_field();
      issue(12'o6232);
      // R3
      chk(irq_inhibit === 1'b1, "R3", irq_inhibit, 1);
      chk(ifield === 3'd0, "R3", ifield, 0);
      read_ac(12'o6224, 12'o0000, "R6");
      pulse_commit();
      // R4
      chk(ifield === 3'd3, "R4", ifield, 3);
      chk(irq_inhibit === 1'b0, "R4", irq_inhibit, 0);
      read_ac(12'o6224, 12'o0030, "R6");
      pulse_commit();
      chk(ifield === 3'd3, "R4", ifield, 3);
      addr_sel = 1'b0; addr_in = 12'o0100; #1;
      chk(full_addr === 15'o30100, "R10", full_addr, 15'o30100);
   endtask

   task automatic t_interrupt();
      pulse_irq();
      // R9
      chk(ifield === 3'd0 && dfield === 3'd0, "R9", {ifield, dfield}, 0);
      read_ac(12'o6234, 12'o0035, "R7");
   endtask

   task automatic t_restore();
      issue(12'o6244);
      // R8
      chk(dfield === 3'd5, "R8", dfield, 5);
      chk(irq_inhibit === 1'b1, "R8", irq_inhibit, 1);
      chk(ifield === 3'd0, "R8", ifield, 0);
      pulse_commit();
      chk(ifield === 3'd3, "R8", ifield, 3);
      chk(irq_inhibit === 1'b0, "R8", irq_inhibit, 0);
   endtask

   task automatic t_ignored();
      logic [11:0] words [4] = '{12'o6054, 12'o6215, 12'o6264, 12'o6273};
      foreach (words[k]) begin
         @(negedge clk);
         instr = words[k]; instr_valid = 1'b1; #1;
         // R11
         chk(ac_rd_load === 1'b0, "R11", ac_rd_load, 0);
         @(negedge clk);
         instr_valid = 1'b0;
         chk(ifield === 3'd3 && dfield === 3'd5 && !irq_inhibit, "R11",
             {irq_inhibit, ifield, dfield}, 12'o035);
      end
      @(negedge clk);
      instr = 12'o6214; instr_valid = 1'b0; #1;
      chk(ac_rd_load === 1'b0, "R11", ac_rd_load, 0);
      instr = 12'o6211;
      @(negedge clk);
      chk(dfield === 3'd5, "R11", dfield, 5);
      instr = '0;
   endtask

   task automatic t_irq_wins();
      @(negedge clk);
      instr = 12'o6262; instr_valid = 1'b1; irq_enter = 1'b1;
      @(negedge clk);
      instr_valid = 1'b0; irq_enter = 1'b0; instr = '0;
      // R9
      chk(ifield === 3'd0 && dfield === 3'd0, "R9", {ifield, dfield}, 0);
      chk(irq_inhibit === 1'b0, "R9", irq_inhibit, 0);
      read_ac(12'o6234, 12'o0035, "R9");
   endtask

   initial begin
      #400000;
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_data_field();
      t_instr_field();
      t_interrupt();
      t_restore();
      t_ignored();
      t_irq_wins();
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule